// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address that a synchronous burst memory presents to its storage array. When an address strobe is accepted, it captures a start address. From then on, each clock with the advance input asserted moves to the next beat of a four-beat burst. Only the two low address bits change during a burst. A static order input chooses how they change: an XOR-based interleaved order, or a linear order that wraps inside the four-word block. Storage, byte-lane write control and output pipelining belong to neighbouring logic.

The surrounding controller decodes its chip enables into one qualifier. It passes the two active-low strobes through separately, and the block accepts a load when either strobe is low while the qualifier is high. On the board, the order input is expected to have a pull-up, so an undriven pin selects interleaved order. The current address is a registered start value combined with a beat count. It updates on the clock edge that follows a load or an advance.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the generator clears, and `addr_o` reads zero after that edge.
- R2: A load happens at an edge where `ce_ok_i` is 1 and at least one of `strb_p_n_i` and `strb_c_n_i` is 0 (either one alone or both). After that edge, `addr_o` equals `addr_i`.
- R3: When `ce_ok_i` is 0, or when both strobes are 1, no load happens and `addr_i` has no effect on `addr_o`.
- R4: When no load happens, `adv_n_i` = 0 moves to the next beat after the edge. `adv_n_i` = 1 keeps the beat unchanged.
- R5: With `mode_i` = 1 (interleaved), `addr_o[1:0]` is the loaded offset XOR the beat count. A start of 1 gives 1,0,3,2 and a start of 2 gives 2,3,0,1.
- R6: With `mode_i` = 0 (linear), `addr_o[1:0]` is (loaded offset + beat count) mod 4. A start of 3 gives 3,0,1,2.
- R7: `addr_o[16:2]` keeps the loaded value through any number of advances.
- R8: An advance after the fourth beat returns `addr_o[1:0]` to the loaded offset. The burst does not leave its four-word block.
- R9: If a load and an advance happen at the same edge, the load wins and the beat count restarts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | 17 | Start address offered with a strobe |
| ce_ok_i | input | 1 | 1 when every chip enable is active |
| strb_p_n_i | input | 1 | First address strobe, active low |
| strb_c_n_i | input | 1 | Second address strobe, active low |
| adv_n_i | input | 1 | Advance to next beat, active low |
| mode_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr_o | output | 17 | Current word address |

## Verification
The bench builds the block with its default parameters: a 17-bit address and a 2-bit beat field. With these values, every offset and wrap point of a burst is reached in a few cycles. Both orders run from every start offset. The bench also covers the strobe and enable combinations that gate loading, including loads that collide with an advance. A random phase of several hundred cycles mixes loads, advances, idles and order changes, and it is compared on every clock against a behavioural model.

// File: rtl/bas_pkg.sv
package bas_pkg;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } burst_order_e;

   // Number of beats for a beat field of the given width
   function automatic int unsigned beats_of(input int unsigned bw);
      return 32'd1 << bw;
   endfunction

endpackage

// File: rtl/bas_load_qual.sv
module bas_load_qual #(
   parameter int unsigned N_STRB = 2
) (
   input  logic              ce_ok_i,
   input  logic [N_STRB-1:0] strb_n_i,
   output logic              load_o
);

   generate
      if (N_STRB < 1) begin : g_bad_strb
         $error("bas_load_qual: N_STRB must be at least 1");
      end
   endgenerate

   logic [N_STRB-1:0] strb_act;

   genvar gi;
   generate
      for (gi = 0; gi < N_STRB; gi++) begin : g_strb
         assign strb_act[gi] = ~strb_n_i[gi];
      end
   endgenerate

   assign load_o = ce_ok_i & (|strb_act);

   // R3: no strobe active or enables off means no load
   always_comb begin
      a_r3_no_load: assert ((ce_ok_i && (strb_n_i != {N_STRB{1'b1}})) || !load_o);
   end

endmodule

// File: rtl/bas_beat_counter.sv
module bas_beat_counter #(
   parameter int unsigned BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld_i,
   input  logic              step_i,
   output logic [BEAT_W-1:0] cnt_o
);

   generate
      if (BEAT_W < 1) begin : g_bad_beat
         $error("bas_beat_counter: BEAT_W must be at least 1");
      end
   endgenerate

   logic [BEAT_W-1:0] cnt_q;
   logic [BEAT_W-1:0] cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (ld_i)
         cnt_d = '0;
      else if (step_i)
         cnt_d = cnt_q + 1'b1;   // natural wrap gives the block wrap
   end

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else
         cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;

   a_r9_load_clears: assert property (@(posedge clk) disable iff (rst)
      ld_i |=> (cnt_q == '0));

   a_r4_hold: assert property (@(posedge clk) disable iff (rst)
      (!ld_i && !step_i) |=> $stable(cnt_q));

   a_r8_step_wraps: assert property (@(posedge clk) disable iff (rst)
      (!ld_i && step_i && (cnt_q == {BEAT_W{1'b1}})) |=> (cnt_q == '0));

endmodule

// File: rtl/bas_offset_map.sv
module bas_offset_map #(
   parameter int unsigned BEAT_W = 2
) (
   input  logic [BEAT_W-1:0]    start_i,
   input  logic [BEAT_W-1:0]    cnt_i,
   input  bas_pkg::burst_order_e order_i,
   output logic [BEAT_W-1:0]    off_o
);

   logic [BEAT_W-1:0] off_xor;
   logic [BEAT_W-1:0] off_lin;

   genvar gi;
   generate
      for (gi = 0; gi < BEAT_W; gi++) begin : g_xor
         assign off_xor[gi] = start_i[gi] ^ cnt_i[gi];
      end
   endgenerate

   assign off_lin = start_i + cnt_i;

   assign off_o = (order_i == bas_pkg::ORD_INTERLEAVE) ? off_xor : off_lin;

   // R8: beat zero always lands on the loaded offset in either order
   always_comb begin
      a_r8_first_beat: assert ((cnt_i != '0) || (off_o == start_i));
   end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              ce_ok_i,
   input  logic              strb_p_n_i,
   input  logic              strb_c_n_i,
   input  logic              adv_n_i,
   input  logic              mode_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int unsigned HI_W = ADDR_W - BEAT_W;

   generate
      if (BEAT_W < 1 || BEAT_W >= ADDR_W) begin : g_bad_width
         $error("burst_addr_seq: need 1 <= BEAT_W < ADDR_W");
      end
   endgenerate

   logic              load;
   logic [BEAT_W-1:0] cnt;
   logic [BEAT_W-1:0] off;
   logic [ADDR_W-1:0] base_q;
   bas_pkg::burst_order_e order;

   assign order = bas_pkg::burst_order_e'(mode_i);

   bas_load_qual #(.N_STRB(2)) u_qual (
      .ce_ok_i  (ce_ok_i),
      .strb_n_i ({strb_c_n_i, strb_p_n_i}),
      .load_o   (load)
   );

   always_ff @(posedge clk) begin
      if (rst)
         base_q <= '0;
      else if (load)
         base_q <= addr_i;
   end

   bas_beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .ld_i   (load),
      .step_i (~adv_n_i),
      .cnt_o  (cnt)
   );

   bas_offset_map #(.BEAT_W(BEAT_W)) u_map (
      .start_i (base_q[BEAT_W-1:0]),
      .cnt_i   (cnt),
      .order_i (order),
      .off_o   (off)
   );

   assign addr_o = {base_q[ADDR_W-1:BEAT_W], off};

   a_r2_capture: assert property (@(posedge clk) disable iff (rst)
      load |=> (addr_o == $past(addr_i)));

   a_r7_upper_hold: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

   a_r1_reset_zero: assert property (@(posedge clk)
      rst |=> (addr_o == '0));

   localparam int unsigned HI_W_CHK = HI_W;
   generate
      if (HI_W_CHK == 0) begin : g_no_hi
         $error("burst_addr_seq: no upper address bits");
      end
   endgenerate

endmodule

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [16:0] addr_i = '0;
   logic        ce_ok_i = 1'b0;
   logic        strb_p_n_i = 1'b1;
   logic        strb_c_n_i = 1'b1;
   logic        adv_n_i = 1'b1;
   logic        mode_i = 1'b1;
   logic [16:0] addr_o;

   int n_chk = 0;
   int n_bad = 0;

   // reference model state
   int ref_start = 0;
   int ref_cnt   = 0;

   always #4 clk = ~clk;

   burst_addr_seq u0 (
      .clk(clk), .rst(rst), .addr_i(addr_i), .ce_ok_i(ce_ok_i),
      .strb_p_n_i(strb_p_n_i), .strb_c_n_i(strb_c_n_i),
      .adv_n_i(adv_n_i), .mode_i(mode_i), .addr_o(addr_o)
   );

   always @(posedge clk) begin
      if (rst) begin
         ref_start <= 0;
         ref_cnt   <= 0;
      end else if (ce_ok_i && (!strb_p_n_i || !strb_c_n_i)) begin
         ref_start <= int'(addr_i);
         ref_cnt   <= 0;
      end else if (!adv_n_i) begin
         ref_cnt   <= (ref_cnt + 1) % 4;
      end
   end

   function automatic int expect_addr();
      int lo;
      int s;
      s = ref_start % 4;
      if (mode_i) lo = s ^ ref_cnt;
      else        lo = (s + ref_cnt) % 4;
      return (ref_start / 4) * 4 + lo;
   endfunction

   task automatic check(input int exp, input string tag);
      n_chk++;
      if (int'(addr_o) != exp) begin
         n_bad++;
         $display("FAIL %s: addr_o=%05h expected=%05h", tag, addr_o, exp);
      end
   endtask

   // advance one clock, then compare against model and optional fixed value
   task automatic tick(input string tag, input int fixed = -1);
      @(negedge clk);
      check(expect_addr(), tag);
      if (fixed >= 0) check(fixed, tag);
   endtask

   task automatic set_in(input logic ce, input logic sp, input logic sc,
                         input logic av, input logic [16:0] a);
      ce_ok_i = ce; strb_p_n_i = sp; strb_c_n_i = sc; adv_n_i = av; addr_i = a;
   endtask

   initial begin
      #(200000 * 8);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      // R1 reset
      set_in(1'b1, 1'b0, 1'b1, 1'b0, 17'h1ffff);
      tick("R1", 0);
      tick("R1", 0);
      rst = 1'b0;

      // R2 + R5: interleaved start 2 via first strobe, then R8 wrap
      mode_i = 1'b1;
      set_in(1'b1, 1'b0, 1'b1, 1'b1, 17'h1abc6);
      tick("R2", 17'h1abc6);
      set_in(1'b0, 1'b1, 1'b1, 1'b0, 17'h00000);
      tick("R5", 17'h1abc7);
      tick("R5", 17'h1abc4);
      tick("R7", 17'h1abc5);
      tick("R8", 17'h1abc6);
      tick("R8", 17'h1abc7);

      // R5 interleaved start 1 via second strobe
      set_in(1'b1, 1'b1, 1'b0, 1'b1, 17'h00201);
      tick("R2", 17'h00201);
      set_in(1'b1, 1'b1, 1'b1, 1'b0, 17'h0ffff);
      tick("R5", 17'h00200);
      tick("R5", 17'h00203);
      tick("R5", 17'h00202);
      tick("R8", 17'h00201);

      // R6 linear start 3, with holds for R4
      mode_i = 1'b0;
      set_in(1'b1, 1'b0, 1'b0, 1'b1, 17'h15553);
      tick("R2", 17'h15553);
      set_in(1'b0, 1'b0, 1'b0, 1'b0, 17'h0aaaa);
      tick("R6", 17'h15550);
      set_in(1'b0, 1'b1, 1'b1, 1'b1, 17'h0aaaa);
      tick("R4", 17'h15550);
      tick("R4", 17'h15550);
      set_in(1'b0, 1'b1, 1'b1, 1'b0, 17'h0aaaa);
      tick("R6", 17'h15551);
      tick("R6", 17'h15552);
      tick("R8", 17'h15553);

      // R3: enables off with strobe low, then strobes both high
      set_in(1'b0, 1'b0, 1'b0, 1'b1, 17'h01234);
      tick("R3", 17'h15553);
      set_in(1'b1, 1'b1, 1'b1, 1'b1, 17'h01234);
      tick("R3", 17'h15553);

      // R9: load collides with advance mid-burst, linear start 2
      set_in(1'b1, 1'b1, 1'b1, 1'b0, 17'h01234);
      tick("R3", 17'h15550);
      set_in(1'b1, 1'b0, 1'b1, 1'b0, 17'h0c3f2);
      tick("R9", 17'h0c3f2);
      set_in(1'b0, 1'b1, 1'b1, 1'b0, 17'h00000);
      tick("R9", 17'h0c3f3);
      tick("R6", 17'h0c3f0);

      // random mix compared with model each clock
      for (int i = 0; i < 600; i++) begin
         set_in(($urandom % 4) != 0, ($urandom % 3) != 0, ($urandom % 3) != 0,
                ($urandom % 3) == 0, 17'($urandom));
         if (($urandom % 16) == 0) mode_i = ~mode_i;
         tick("R4");
      end

      // R1 again mid-run
      rst = 1'b1;
      tick("R1", 0);
      rst = 1'b0;

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule